// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the write path of a byte-wide flash device. It watches each write cycle (address and data) and finds the command sequences that start array operations. A standard program needs two unlock writes, a program code and then one address/data write. A bulk erase needs six writes. A third command write after the unlock pair moves the decoder into an unlock-bypass mode. In that mode a program takes only two writes, and a two-write exit sequence returns the decoder to read mode.

When a sequence completes, the decoder sends a one-cycle strobe to the array controller. A program strobe carries the captured address and data. An erase strobe carries nothing. The decoder then reports busy until the array controller drops its busy input. Any wrong write inside a standard sequence sends the decoder back to read mode. The mode output tells the surrounding logic whether reads should see the array, the bypass state or status.

States: `ST_READ` (read mode, waiting for the first unlock write), `ST_UNL1` (first unlock seen), `ST_UNL2` (both unlock writes seen), `ST_PRG_ARM` (standard program code seen), `ST_ERS1` (erase code seen), `ST_ERS2` (first unlock of the erase tail seen), `ST_ERS3` (second unlock of the erase tail seen), `ST_BYP` (bypass mode, idle), `ST_BYP_PRG` (bypass program code seen), `ST_BYP_RST` (first write of bypass exit seen), `ST_BUSY` (array operation in progress).

Transitions:
- `ST_READ`→`ST_UNL1` on AAh@555h.
- `ST_UNL1`→`ST_UNL2` on 55h@2AAh.
- `ST_UNL2`→`ST_PRG_ARM` on A0h@555h, →`ST_ERS1` on 80h@555h, →`ST_BYP` on 20h@555h.
- `ST_PRG_ARM`→`ST_BUSY` on any write (program launch).
- `ST_ERS1`→`ST_ERS2` on AAh@555h.
- `ST_ERS2`→`ST_ERS3` on 55h@2AAh.
- `ST_ERS3`→`ST_BUSY` on 10h@555h (erase launch).
- Every other write in the unlock and erase states goes back to `ST_READ`.
- `ST_BYP`→`ST_BYP_PRG` on A0h, →`ST_BYP_RST` on 90h, and stays put on anything else.
- `ST_BYP_PRG`→`ST_BUSY` on any write.
- `ST_BYP_RST`→`ST_READ` on 00h, otherwise back to `ST_BYP`.
- `ST_BUSY`→`ST_BYP` or `ST_READ` when the busy input is low, depending on where the operation was launched from.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (read) and both `prog_strobe` and `erase_start` are low.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h, then any address/data raise `prog_strobe` for exactly the cycle after the last write. In that cycle `prog_addr`/`prog_data` equal that write and `mode` is 2 (busy). Command addresses compare only the low 11 address bits.
- R3: The writes AAh@555h, 55h@2AAh, 20h@555h put `mode` at 1 (bypass) in the cycle after the third write.
- R4: In bypass mode, a write of A0h at any address followed by any address/data write raises `prog_strobe` with that address and data. This repeats with no unlock writes. After the operation, the decoder returns to bypass.
- R5: In bypass mode, any write whose data is neither A0h nor 90h is ignored. No strobe is raised and `mode` stays 1. This includes the unlock and erase codes.
- R6: In bypass mode, 90h then 00h at any addresses sets `mode` to 0 in the cycle after the 00h write. If the second write is 90h followed by anything other than 00h, the decoder stays in bypass.
- R7: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h raise `erase_start` for exactly the cycle after the sixth write, with `mode` at 2.
- R8: A write in a standard sequence with the wrong data or the wrong address returns the decoder to read mode. A new sequence must then restart from its first unlock write.
- R9: While `mode` is 2, writes are ignored. `mode` stays 2 while `array_busy` is high. In the cycle after `array_busy` is seen low, `mode` returns to 1 if the operation was launched from bypass, and to 0 otherwise.
- R10: `prog_strobe` and `erase_start` each last one cycle and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | A write cycle is present this clock |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| array_busy | input | 1 | Array controller is running an operation |
| prog_strobe | output | 1 | One-cycle program request |
| prog_addr | output | ADDR_W | Address for the program request |
| prog_data | output | 8 | Data for the program request |
| erase_start | output | 1 | One-cycle bulk erase request |
| mode | output | 2 | 0 read, 1 unlock-bypass, 2 busy |

## Verification
The hardest case to reach is a complete six-write erase that is interleaved with aborts and with bypass entries and exits. Uniform random bytes almost never finish the sequence. The stimulus therefore asks a bench reference model for the write that would advance the current state, and sends that write most of the time. The rest of the time it sends a byte drawn from a pool of command codes and the two unlock addresses, so aborts occur at every step. The array model's busy length is random, so operations launched from both read and bypass modes return along both exit paths. Directed cases add writes during busy and a failed bypass exit.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNL1,
        ST_UNL2,
        ST_PRG_ARM,
        ST_ERS1,
        ST_ERS2,
        ST_ERS3,
        ST_BYP,
        ST_BYP_PRG,
        ST_BYP_RST,
        ST_BUSY
    } fcd_state_t;

    typedef enum logic [1:0] {
        MODE_READ = 2'd0,
        MODE_BYP  = 2'd1,
        MODE_BUSY = 2'd2
    } fcd_mode_t;

    localparam logic [11:0] KEY_ADDR_A = 12'h555;
    localparam logic [11:0] KEY_ADDR_B = 12'h2AA;

    localparam logic [7:0] CODE_KEY1   = 8'hAA;
    localparam logic [7:0] CODE_KEY2   = 8'h55;
    localparam logic [7:0] CODE_PROG   = 8'hA0;
    localparam logic [7:0] CODE_ERASE  = 8'h80;
    localparam logic [7:0] CODE_BULK   = 8'h10;
    localparam logic [7:0] CODE_BYPASS = 8'h20;
    localparam logic [7:0] CODE_EXIT1  = 8'h90;
    localparam logic [7:0] CODE_EXIT2  = 8'h00;

    typedef struct packed {
        logic at_a;
        logic at_b;
        logic d_key1;
        logic d_key2;
        logic d_prog;
        logic d_erase;
        logic d_bulk;
        logic d_bypass;
        logic d_exit1;
        logic d_exit2;
    } fcd_class_t;

endpackage

// File: rtl/fcd_classify.sv
module fcd_classify
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CMD_AW = 11
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    output fcd_class_t        cls
);
    localparam logic [CMD_AW-1:0] MATCH_A = KEY_ADDR_A[CMD_AW-1:0];
    localparam logic [CMD_AW-1:0] MATCH_B = KEY_ADDR_B[CMD_AW-1:0];

    logic [CMD_AW-1:0] low_addr;
    assign low_addr = addr[CMD_AW-1:0];

    always_comb begin
        cls.at_a     = (low_addr == MATCH_A);
        cls.at_b     = (low_addr == MATCH_B);
        cls.d_key1   = (data == CODE_KEY1);
        cls.d_key2   = (data == CODE_KEY2);
        cls.d_prog   = (data == CODE_PROG);
        cls.d_erase  = (data == CODE_ERASE);
        cls.d_bulk   = (data == CODE_BULK);
        cls.d_bypass = (data == CODE_BYPASS);
        cls.d_exit1  = (data == CODE_EXIT1);
        cls.d_exit2  = (data == CODE_EXIT2);
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CMD_AW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              array_busy,
    output logic              prog_strobe,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [7:0]        prog_data,
    output logic              erase_start,
    output logic [1:0]        mode
);
    fcd_state_t st, st_n;
    logic       ret_byp, ret_byp_n;
    logic       launch_prg, launch_ers;
    fcd_class_t c;
    fcd_mode_t  mode_e;

    fcd_classify #(.ADDR_W(ADDR_W), .CMD_AW(CMD_AW)) i_classify (
        .addr(wr_addr),
        .data(wr_data),
        .cls (c)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_READ;
            ret_byp <= 1'b0;
        end else begin
            st      <= st_n;
            ret_byp <= ret_byp_n;
        end
    end

    // transitions
    always_comb begin
        st_n       = st;
        ret_byp_n  = ret_byp;
        launch_prg = 1'b0;
        launch_ers = 1'b0;
        unique case (st)
            ST_READ: if (wr_en && c.at_a && c.d_key1) st_n = ST_UNL1;
            ST_UNL1: if (wr_en) st_n = (c.at_b && c.d_key2) ? ST_UNL2 : ST_READ;
            ST_UNL2: if (wr_en) begin
                if (c.at_a && c.d_prog)        st_n = ST_PRG_ARM;
                else if (c.at_a && c.d_erase)  st_n = ST_ERS1;
                else if (c.at_a && c.d_bypass) st_n = ST_BYP;
                else                           st_n = ST_READ;
            end
            ST_PRG_ARM: if (wr_en) begin
                st_n       = ST_BUSY;
                ret_byp_n  = 1'b0;
                launch_prg = 1'b1;
            end
            ST_ERS1: if (wr_en) st_n = (c.at_a && c.d_key1) ? ST_ERS2 : ST_READ;
            ST_ERS2: if (wr_en) st_n = (c.at_b && c.d_key2) ? ST_ERS3 : ST_READ;
            ST_ERS3: if (wr_en) begin
                if (c.at_a && c.d_bulk) begin
                    st_n       = ST_BUSY;
                    ret_byp_n  = 1'b0;
                    launch_ers = 1'b1;
                end else begin
                    st_n = ST_READ;
                end
            end
            ST_BYP: if (wr_en) begin
                if (c.d_prog)       st_n = ST_BYP_PRG;
                else if (c.d_exit1) st_n = ST_BYP_RST;
            end
            ST_BYP_PRG: if (wr_en) begin
                st_n       = ST_BUSY;
                ret_byp_n  = 1'b1;
                launch_prg = 1'b1;
            end
            ST_BYP_RST: if (wr_en) st_n = c.d_exit2 ? ST_READ : ST_BYP;
            ST_BUSY: if (!array_busy) st_n = ret_byp ? ST_BYP : ST_READ;
            default: st_n = ST_READ;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_strobe <= 1'b0;
            erase_start <= 1'b0;
            prog_addr   <= '0;
            prog_data   <= '0;
        end else begin
            prog_strobe <= launch_prg;
            erase_start <= launch_ers;
            if (launch_prg) begin
                prog_addr <= wr_addr;
                prog_data <= wr_data;
            end
        end
    end

    always_comb begin
        unique case (st)
            ST_BUSY:                       mode_e = MODE_BUSY;
            ST_BYP, ST_BYP_PRG, ST_BYP_RST: mode_e = MODE_BYP;
            default:                       mode_e = MODE_READ;
        endcase
    end
    assign mode = mode_e;

    // checks beside the logic
    p_events_apart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_strobe && erase_start));

    p_prog_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        prog_strobe |=> !prog_strobe);

    p_strobe_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_strobe || erase_start) |-> (mode == MODE_BUSY));

    p_byp_prog_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && st == ST_BYP_PRG) |=>
            (prog_strobe && prog_addr == $past(wr_addr) && prog_data == $past(wr_data)));

    p_byp_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && st == ST_BYP && wr_data != CODE_PROG && wr_data != CODE_EXIT1) |=>
            (mode == MODE_BYP && !prog_strobe && !erase_start));

    p_byp_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && st == ST_BYP_RST && wr_data == CODE_EXIT2) |=> (mode == MODE_READ));

    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BUSY && array_busy) |=>
            (mode == MODE_BUSY && !prog_strobe && !erase_start));
endmodule

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;

    localparam int S_READ = 0, S_U1 = 1, S_U2 = 2, S_PA = 3, S_E1 = 4, S_E2 = 5,
                   S_E3 = 6, S_BYP = 7, S_BP = 8, S_BR = 9, S_BUSY = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              array_busy;
    logic              prog_strobe;
    logic [ADDR_W-1:0] prog_addr;
    logic [7:0]        prog_data;
    logic              erase_start;
    logic [1:0]        mode;

    int unsigned arr_cnt;
    int unsigned arr_lat = 2;
    int n_cmp = 0;
    int n_bad = 0;

    int m_st = S_READ;
    bit m_ret = 1'b0;
    bit e_prg, e_ers;
    logic [ADDR_W-1:0] e_addr;
    logic [7:0]        e_data;
    string m_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(ADDR_W)) i_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .array_busy(array_busy), .prog_strobe(prog_strobe), .prog_addr(prog_addr),
        .prog_data(prog_data), .erase_start(erase_start), .mode(mode)
    );

    // simple array controller model
    assign array_busy = prog_strobe | erase_start | (arr_cnt != 0);
    always_ff @(posedge clk) begin
        if (!rst_n)                       arr_cnt <= 0;
        else if (prog_strobe | erase_start) arr_cnt <= arr_lat;
        else if (arr_cnt != 0)            arr_cnt <= arr_cnt - 1;
    end

    function automatic bit at_a(logic [ADDR_W-1:0] a);
        return a[10:0] == 11'h555;
    endfunction
    function automatic bit at_b(logic [ADDR_W-1:0] a);
        return a[10:0] == 11'h2AA;
    endfunction
    function automatic int exp_mode(int s);
        if (s == S_BUSY) return 2;
        if (s == S_BYP || s == S_BP || s == S_BR) return 1;
        return 0;
    endfunction

    task automatic model_step(bit en, logic [ADDR_W-1:0] a, logic [7:0] d, bit busy);
        e_prg = 1'b0;
        e_ers = 1'b0;
        m_tag = (exp_mode(m_st) == 1) ? "R5" : "R8";
        if (m_st == S_BUSY) begin
            m_tag = "R9";
            if (!busy) m_st = m_ret ? S_BYP : S_READ;
        end else if (en) begin
            case (m_st)
                S_READ: if (at_a(a) && d == 8'hAA) m_st = S_U1;
                S_U1: m_st = (at_b(a) && d == 8'h55) ? S_U2 : S_READ;
                S_U2: begin
                    if (at_a(a) && d == 8'hA0) m_st = S_PA;
                    else if (at_a(a) && d == 8'h80) m_st = S_E1;
                    else if (at_a(a) && d == 8'h20) begin m_st = S_BYP; m_tag = "R3"; end
                    else m_st = S_READ;
                end
                S_PA: begin
                    m_st = S_BUSY; m_ret = 1'b0; e_prg = 1'b1; e_addr = a; e_data = d; m_tag = "R2";
                end
                S_E1: m_st = (at_a(a) && d == 8'hAA) ? S_E2 : S_READ;
                S_E2: m_st = (at_b(a) && d == 8'h55) ? S_E3 : S_READ;
                S_E3: begin
                    if (at_a(a) && d == 8'h10) begin
                        m_st = S_BUSY; m_ret = 1'b0; e_ers = 1'b1; m_tag = "R7";
                    end else m_st = S_READ;
                end
                S_BYP: begin
                    if (d == 8'hA0) begin m_st = S_BP; m_tag = "R4"; end
                    else if (d == 8'h90) begin m_st = S_BR; m_tag = "R6"; end
                end
                S_BP: begin
                    m_st = S_BUSY; m_ret = 1'b1; e_prg = 1'b1; e_addr = a; e_data = d; m_tag = "R4";
                end
                S_BR: begin
                    m_st = (d == 8'h00) ? S_READ : S_BYP; m_tag = "R6";
                end
                default: m_st = S_READ;
            endcase
        end
    endtask

    task automatic check(bit ok, string tag, string what, int act, int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, expv, $time);
        end
    endtask

    task automatic cyc(bit en, logic [ADDR_W-1:0] a, logic [7:0] d);
        wr_en = en; wr_addr = a; wr_data = d;
        model_step(en, a, d, array_busy);
        @(negedge clk);
        check(int'(mode) == exp_mode(m_st), m_tag, "mode", int'(mode), exp_mode(m_st));
        check(prog_strobe == e_prg, m_tag, "prog_strobe", int'(prog_strobe), int'(e_prg));
        check(erase_start == e_ers, m_tag, "erase_start", int'(erase_start), int'(e_ers));
        check(!(prog_strobe && erase_start), "R10", "strobe overlap", 1, 0);
        if (e_prg) begin
            check(prog_addr == e_addr, m_tag, "prog_addr", int'(prog_addr), int'(e_addr));
            check(prog_data == e_data, m_tag, "prog_data", int'(prog_data), int'(e_data));
        end
    endtask

    task automatic unlock();
        cyc(1'b1, 16'h0555, 8'hAA);
        cyc(1'b1, 16'h02AA, 8'h55);
    endtask

    task automatic drain();
        while (m_st == S_BUSY) cyc(1'b0, '0, '0);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic intended(output logic [ADDR_W-1:0] a, output logic [7:0] d);
        logic [7:0] pick3 [3];
        pick3 = '{8'hA0, 8'h80, 8'h20};
        a = ADDR_W'($urandom);
        d = 8'($urandom);
        case (m_st)
            S_READ, S_E1: begin a = 16'h0555; d = 8'hAA; end
            S_U1, S_E2:   begin a = 16'h02AA; d = 8'h55; end
            S_U2:         begin a = 16'h0555; d = pick3[$urandom % 3]; end
            S_E3:         begin a = 16'h0555; d = 8'h10; end
            S_BYP:        d = ($urandom % 3 == 0) ? 8'h90 : 8'hA0;
            S_BR:         d = ($urandom % 4 == 0) ? 8'h90 : 8'h00;
            default: ;
        endcase
    endtask

    task automatic pool(output logic [ADDR_W-1:0] a, output logic [7:0] d);
        logic [7:0] codes [9];
        int k;
        codes = '{8'hAA, 8'h55, 8'hA0, 8'h80, 8'h10, 8'h20, 8'h90, 8'h00, 8'h3C};
        k = $urandom % 3;
        a = (k == 0) ? 16'h0555 : (k == 1) ? 16'h02AA : ADDR_W'($urandom);
        if ($urandom % 2 == 0) a[15:11] = 5'($urandom);
        d = codes[$urandom % 9];
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        report();
    end

    initial begin
        logic [ADDR_W-1:0] ra;
        logic [7:0] rd;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(mode == 2'd0, "R1", "reset mode", int'(mode), 0);
        check(!prog_strobe && !erase_start, "R1", "reset strobes", int'(prog_strobe), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 standard program
        unlock(); cyc(1'b1, 16'h0555, 8'hA0); cyc(1'b1, 16'h1234, 8'h5A); drain();
        // R8 upper address bits ignored, wrong address aborts
        unlock(); cyc(1'b1, 16'hF555, 8'hA0); cyc(1'b1, 16'h00FF, 8'hC3); drain();
        cyc(1'b1, 16'h0555, 8'hAA); cyc(1'b1, 16'h02AB, 8'h55);
        cyc(1'b1, 16'h02AA, 8'h55); cyc(1'b1, 16'h0555, 8'hA0);  // must not arm
        // R7 bulk erase, then abort on step five
        unlock(); cyc(1'b1, 16'h0555, 8'h80); unlock(); cyc(1'b1, 16'h0555, 8'h10);
        // R9 writes during busy ignored
        cyc(1'b1, 16'h0555, 8'hAA); cyc(1'b1, 16'h02AA, 8'h55); drain();
        unlock(); cyc(1'b1, 16'h0555, 8'h80); cyc(1'b1, 16'h0555, 8'hAA); cyc(1'b1, 16'h02AA, 8'h54);
        cyc(1'b1, 16'h0555, 8'h10);
        // R3 bypass entry, R4 two programs, R5 ignored writes, R6 exits
        unlock(); cyc(1'b1, 16'h0555, 8'h20);
        cyc(1'b1, 16'h0777, 8'hA0); cyc(1'b1, 16'h4321, 8'h11); drain();
        cyc(1'b1, 16'h0000, 8'hA0); cyc(1'b1, 16'hFFFF, 8'hEE); drain();
        cyc(1'b1, 16'h0555, 8'hAA); cyc(1'b1, 16'h02AA, 8'h55); cyc(1'b1, 16'h0555, 8'h80);
        cyc(1'b1, 16'h0555, 8'h10); cyc(1'b1, 16'h0123, 8'h00);
        cyc(1'b1, 16'h0100, 8'h90); cyc(1'b1, 16'h0100, 8'h55);
        cyc(1'b1, 16'h0ABC, 8'h90); cyc(1'b1, 16'h0DEF, 8'h00);
        cyc(1'b1, 16'h0321, 8'hA0);

        // random mix
        for (int i = 0; i < 6000; i++) begin
            int r;
            if (m_st != S_BUSY) arr_lat = 1 + $urandom % 4;
            r = $urandom % 10;
            if (r < 2) cyc(1'b0, ADDR_W'($urandom), 8'($urandom));
            else begin
                if (r < 8) intended(ra, rd);
                else       pool(ra, rd);
                cyc(1'b1, ra, rd);
            end
        end
        report();
    end
endmodule